// File: doc/BRIEF.md
# Role-Gated Accelerator Bank Shell

This block sits between a host word port and one user accelerator. It holds a parameterised set of single-port local RAM banks and a small file of shared control/status registers. Every bank has a fixed role that follows from its index: constant, input, bidirectional or output. The role decides which side may write the bank and which side may read it. A round handshake hands the banks to the accelerator and returns them to the host afterwards. The host raises `h_go`. The shell sends a one-cycle `k_start` to the accelerator and holds the banks for the kernel until the accelerator raises `k_ready`.

The host writes the input and bidirectional banks before a round, and it reads the output and bidirectional banks after the round. Constant banks can only be loaded while a load window is open. The window opens at reset and on a host reload request, and it closes when a round starts. Host requests that break these rules are dropped and latch an error flag. A running count of the words the host has written into the banks is presented to the accelerator, and this count restarts with every round.

Top module: `acc_bank_shell`

## Requirements
- R1: Bank indices are ordered by role: indices 0 to N_CONST-1 are constant banks, then N_IN input banks, then N_INOUT bidirectional banks, then N_OUT output banks. The defaults are one bank of each role, so index 0 is constant, 1 is input, 2 is bidirectional and 3 is output.
- R2: While no round is running, a host write (`h_req`=1, `h_reg`=0, `h_we`=1) is stored in the addressed word in these cases: the bank is an input bank, the bank is a bidirectional bank, or the bank is a constant bank and the load window is open.
- R3: Every host read request (`h_we`=0) gives `h_rvalid`=1 in the next cycle, with `h_rdata` valid in that same cycle. Accepted reads are register reads and, while idle, reads of output and bidirectional banks. Every other read returns zero.
- R4: The following host requests are dropped and set `h_err`: a write to an output bank, a read of a constant or input bank, an index outside the banks or registers, and a word address of DEPTH or above. `h_err` then stays at 1 until reset.
- R5: While `h_busy`=1, the host cannot write or read any bank. A blocked write leaves the memory unchanged and a blocked read returns zero.
- R6: While `h_busy`=1, the kernel may read constant, input and bidirectional banks, with `k_rdata` following one cycle after the request. It may write bidirectional and output banks. A kernel write to a constant or input bank is dropped.
- R7: The constant load window is open after reset and after `h_reload` is raised while idle. It closes at the start of a round, and a constant-bank write made while the window is closed is dropped.
- R8: When `h_go` is raised while idle, `k_start` is 1 for exactly one cycle, starting in the next cycle, and `h_busy` rises in that same cycle. `h_go` raised while `h_busy`=1 produces no start.
- R9: `h_busy` falls in the cycle after `k_ready` rises during a round.
- R10: `k_count` adds one for each accepted host bank write, and register writes do not count. It reads 0 in the cycle in which `k_start` is 1.
- R11: A host write to register r sets `k_reg_val[r]` in the next cycle. A kernel strobe `k_reg_vld[r]` loads `k_reg_wr[r]` into the same register and wins over a host write made in the same cycle. A host read of register r returns its current value.
- R12: After reset, `h_err`, `h_busy`, `k_start`, `h_rvalid` and `k_count` are 0, every register reads 0, and the constant load window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request, one word per cycle |
| h_we | input | 1 | Host write (1) or read (0) |
| h_reg | input | 1 | Host targets the register file (1) or a bank (0) |
| h_idx | input | IDX_W | Bank or register index |
| h_addr | input | ADDR_W | Word address inside the bank |
| h_wdata | input | DATA_W | Host write data |
| h_go | input | 1 | Host request to start a round |
| h_reload | input | 1 | Reopen the constant load window |
| h_rvalid | output | 1 | Host read return strobe |
| h_rdata | output | DATA_W | Host read data |
| h_err | output | 1 | Sticky access error |
| h_busy | output | 1 | A round is running |
| k_start | output | 1 | Round start pulse to the accelerator |
| k_ready | input | 1 | Accelerator round-complete level |
| k_en | input | NB | Kernel bank enable, one bit per bank |
| k_we | input | NB | Kernel bank write enable |
| k_addr | input | NB x ADDR_W | Kernel bank word address |
| k_wdata | input | NB x DATA_W | Kernel bank write data |
| k_rdata | output | NB x DATA_W | Kernel bank read data |
| k_reg_val | output | N_REG x DATA_W | Register values seen by the kernel |
| k_reg_vld | input | N_REG | Kernel register update strobe |
| k_reg_wr | input | N_REG x DATA_W | Kernel register update value |
| k_count | output | 32 | Host bank-write word count |

## Verification
Four kinds of result appear one clock edge after the stimulus that causes them: a host read return, a kernel read return, a register update and the counter step. The start pulse, the busy rise and the counter clear also share the edge that samples `h_go`, and busy falls at the edge that first sees `k_ready` high. The bench drives every input on the falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. Dropped accesses are judged at the ports: a blocked write is followed by a read of the same word through whichever side may still read it, and a blocked read must return zero with `h_rvalid` still high.

// File: rtl/acc_shell_pkg.sv
package acc_shell_pkg;

   typedef enum logic [1:0] {
      ROLE_CONST = 2'd0,
      ROLE_IN    = 2'd1,
      ROLE_INOUT = 2'd2,
      ROLE_OUT   = 2'd3
   } bank_role_e;

   // R1: role follows from the bank index and the per-role counts
   function automatic bank_role_e role_of(input int idx, input int nc,
                                          input int ni, input int nio);
      if (idx < nc)             return ROLE_CONST;
      if (idx < nc + ni)        return ROLE_IN;
      if (idx < nc + ni + nio)  return ROLE_INOUT;
      return ROLE_OUT;
   endfunction

endpackage

// File: rtl/acc_round_ctl.sv
module acc_round_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic h_go,
   input  logic h_reload,
   input  logic k_ready,
   output logic go_take,
   output logic k_start,
   output logic busy,
   output logic load_open
);
   logic ready_q;

   assign go_take = h_go && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k_start   <= 1'b0;
         busy      <= 1'b0;
         load_open <= 1'b1;
         ready_q   <= 1'b0;
      end else begin
         ready_q <= k_ready;
         k_start <= go_take;
         if (go_take) begin
            busy      <= 1'b1;
            load_open <= 1'b0;
         end else begin
            if (busy && k_ready && !ready_q && !k_start) busy <= 1'b0;
            if (h_reload && !busy) load_open <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 16,
   parameter acc_shell_pkg::bank_role_e ROLE = acc_shell_pkg::ROLE_IN,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              load_open,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic              h_ok,
   input  logic              k_en,
   input  logic              k_we,
   input  logic [ADDR_W-1:0] k_addr,
   input  logic [DATA_W-1:0] k_wdata,
   output logic [DATA_W-1:0] rdata
);
   import acc_shell_pkg::*;

   localparam bit IS_CONST = (ROLE == ROLE_CONST);
   localparam bit H_WR     = (ROLE == ROLE_IN)  || (ROLE == ROLE_INOUT);
   localparam bit H_RD     = (ROLE == ROLE_OUT) || (ROLE == ROLE_INOUT);
   localparam bit K_WR     = (ROLE == ROLE_OUT) || (ROLE == ROLE_INOUT);
   localparam bit K_RD     = (ROLE != ROLE_OUT);

   logic [DATA_W-1:0] mem [DEPTH];
   logic h_in_rng, k_in_rng, h_wr_ok, h_rd_ok, k_wr_ok, k_rd_ok;

   assign h_in_rng = int'(h_addr) < DEPTH;
   assign k_in_rng = int'(k_addr) < DEPTH;
   assign h_wr_ok  = h_wr && !busy && h_in_rng && (H_WR || (IS_CONST && load_open));
   assign h_rd_ok  = h_rd && !busy && h_in_rng && H_RD;
   assign k_wr_ok  = k_en && k_we  && busy && k_in_rng && K_WR;
   assign k_rd_ok  = k_en && !k_we && busy && k_in_rng && K_RD;
   assign h_ok     = h_wr_ok || h_rd_ok;

   always_ff @(posedge clk) begin
      if (h_wr_ok)      mem[h_addr[AW-1:0]] <= h_wdata;
      else if (k_wr_ok) mem[k_addr[AW-1:0]] <= k_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata <= '0;
      else if (h_rd_ok) rdata <= mem[h_addr[AW-1:0]];
      else if (k_rd_ok) rdata <= mem[k_addr[AW-1:0]];
   end
endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
   parameter int DATA_W = 32,
   parameter int N_REG  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_REG-1:0]              h_wr,
   input  logic [DATA_W-1:0]             h_wdata,
   input  logic [N_REG-1:0]              k_vld,
   input  logic [N_REG-1:0][DATA_W-1:0]  k_data,
   output logic [N_REG-1:0][DATA_W-1:0]  vals
);
   for (genvar r = 0; r < N_REG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)         vals[r] <= '0;
         else if (k_vld[r])  vals[r] <= k_data[r];
         else if (h_wr[r])   vals[r] <= h_wdata;
      end
   end
endmodule

// File: rtl/acc_bank_shell.sv
module acc_bank_shell #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 16,
   parameter int DEPTH   = 16,
   parameter int N_CONST = 1,
   parameter int N_IN    = 1,
   parameter int N_INOUT = 1,
   parameter int N_OUT   = 1,
   parameter int N_REG   = 2,
   localparam int NB     = N_CONST + N_IN + N_INOUT + N_OUT,
   localparam int IDX_N  = (NB > N_REG) ? NB : N_REG,
   localparam int IDX_W  = (IDX_N > 2) ? $clog2(IDX_N) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         h_req,
   input  logic                         h_we,
   input  logic                         h_reg,
   input  logic [IDX_W-1:0]             h_idx,
   input  logic [ADDR_W-1:0]            h_addr,
   input  logic [DATA_W-1:0]            h_wdata,
   input  logic                         h_go,
   input  logic                         h_reload,
   output logic                         h_rvalid,
   output logic [DATA_W-1:0]            h_rdata,
   output logic                         h_err,
   output logic                         h_busy,
   output logic                         k_start,
   input  logic                         k_ready,
   input  logic [NB-1:0]                k_en,
   input  logic [NB-1:0]                k_we,
   input  logic [NB-1:0][ADDR_W-1:0]    k_addr,
   input  logic [NB-1:0][DATA_W-1:0]    k_wdata,
   output logic [NB-1:0][DATA_W-1:0]    k_rdata,
   output logic [N_REG-1:0][DATA_W-1:0] k_reg_val,
   input  logic [N_REG-1:0]             k_reg_vld,
   input  logic [N_REG-1:0][DATA_W-1:0] k_reg_wr,
   output logic [31:0]                  k_count
);
   if (N_CONST + N_IN + N_INOUT < 1) begin : g_no_input_bank
      $error("shell needs at least one bank the host can fill");
   end
   if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("DEPTH must lie in 2 .. 2**ADDR_W");
   end
   if (N_REG < 1) begin : g_no_reg
      $error("N_REG must be at least 1");
   end

   logic              go_take, load_open;
   logic [NB-1:0]     bank_ok;
   logic [N_REG-1:0]  reg_wr;
   logic              reg_idx_ok, bank_hit, bad;
   logic              rd_hit_q, rd_reg_q;
   logic [IDX_W-1:0]  rd_idx_q;
   logic [DATA_W-1:0] reg_rd_q;

   acc_round_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .h_go(h_go), .h_reload(h_reload),
      .k_ready(k_ready), .go_take(go_take), .k_start(k_start),
      .busy(h_busy), .load_open(load_open)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic sel;
      assign sel = h_req && !h_reg && (h_idx == IDX_W'(b));
      acc_bank #(
         .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
         .ROLE(acc_shell_pkg::role_of(b, N_CONST, N_IN, N_INOUT))
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .busy(h_busy), .load_open(load_open),
         .h_wr(sel && h_we), .h_rd(sel && !h_we), .h_addr(h_addr),
         .h_wdata(h_wdata), .h_ok(bank_ok[b]),
         .k_en(k_en[b]), .k_we(k_we[b]), .k_addr(k_addr[b]),
         .k_wdata(k_wdata[b]), .rdata(k_rdata[b])
      );
   end

   for (genvar r = 0; r < N_REG; r++) begin : g_rsel
      assign reg_wr[r] = h_req && h_reg && h_we && (h_idx == IDX_W'(r));
   end

   acc_regs #(.DATA_W(DATA_W), .N_REG(N_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .h_wr(reg_wr), .h_wdata(h_wdata),
      .k_vld(k_reg_vld), .k_data(k_reg_wr), .vals(k_reg_val)
   );

   assign reg_idx_ok = int'(h_idx) < N_REG;
   assign bank_hit   = |bank_ok;
   assign bad        = h_req && (h_reg ? !reg_idx_ok : !bank_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_err    <= 1'b0;
         k_count  <= '0;
         h_rvalid <= 1'b0;
         rd_hit_q <= 1'b0;
         rd_reg_q <= 1'b0;
         rd_idx_q <= '0;
         reg_rd_q <= '0;
      end else begin
         h_err    <= h_err || bad;
         if (go_take) k_count <= '0;
         else if (h_req && h_we && !h_reg && bank_hit) k_count <= k_count + 32'd1;
         h_rvalid <= h_req && !h_we;
         rd_hit_q <= h_req && !h_we && (h_reg ? reg_idx_ok : bank_hit);
         rd_reg_q <= h_reg;
         rd_idx_q <= h_idx;
         for (int r = 0; r < N_REG; r++)
            if (h_idx == IDX_W'(r)) reg_rd_q <= k_reg_val[r];
      end
   end

   always_comb begin
      h_rdata = '0;
      if (rd_hit_q) begin
         if (rd_reg_q) h_rdata = reg_rd_q;
         else
            for (int b = 0; b < NB; b++)
               if (rd_idx_q == IDX_W'(b)) h_rdata = k_rdata[b];
      end
   end
endmodule

// File: rtl/acc_shell_chk.sv
module acc_shell_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        h_req,
   input logic        h_we,
   input logic        h_rvalid,
   input logic        h_err,
   input logic        h_busy,
   input logic        k_start,
   input logic        k_ready,
   input logic [31:0] k_count
);
   a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      k_start |=> !k_start);
   a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      k_start |-> h_busy);
   a_r8_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      h_busy |=> !k_start);
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (h_busy && k_ready && !$past(k_ready) && !k_start) |=> !h_busy);
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      k_start |-> (k_count == 32'd0));
   a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      !k_start |-> (k_count == $past(k_count) || k_count == $past(k_count) + 32'd1));
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      h_err |=> h_err);
   a_r3_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      (h_req && !h_we) |=> h_rvalid);
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_req && !h_we) |=> !h_rvalid);
endmodule

bind acc_bank_shell acc_shell_chk u_chk (
   .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we),
   .h_rvalid(h_rvalid), .h_err(h_err), .h_busy(h_busy),
   .k_start(k_start), .k_ready(k_ready), .k_count(k_count)
);

// File: tb/tb_acc_bank_shell.sv
module tb_acc_bank_shell;
   localparam int NB = 4;
   localparam int NR = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic h_req = 0, h_we = 0, h_reg = 0, h_go = 0, h_reload = 0, k_ready = 0;
   logic [1:0]  h_idx = '0;
   logic [15:0] h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic        h_rvalid, h_err, h_busy, k_start;
   logic [31:0] h_rdata, k_count;
   logic [NB-1:0] k_en = '0, k_we = '0;
   logic [NB-1:0][15:0] k_addr = '0;
   logic [NB-1:0][31:0] k_wdata = '0;
   logic [NB-1:0][31:0] k_rdata;
   logic [NR-1:0][31:0] k_reg_val;
   logic [NR-1:0] k_reg_vld = '0;
   logic [NR-1:0][31:0] k_reg_wr = '0;

   acc_bank_shell dut (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_reg(h_reg),
      .h_idx(h_idx), .h_addr(h_addr), .h_wdata(h_wdata), .h_go(h_go),
      .h_reload(h_reload), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
      .h_err(h_err), .h_busy(h_busy), .k_start(k_start), .k_ready(k_ready),
      .k_en(k_en), .k_we(k_we), .k_addr(k_addr), .k_wdata(k_wdata),
      .k_rdata(k_rdata), .k_reg_val(k_reg_val), .k_reg_vld(k_reg_vld),
      .k_reg_wr(k_reg_wr), .k_count(k_count)
   );

   int tests = 0, fails = 0;
   bit done = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host(input logic we, input logic rg, input logic [1:0] idx,
                       input logic [15:0] addr, input logic [31:0] data);
      @(negedge clk);
      h_req = 1; h_we = we; h_reg = rg; h_idx = idx; h_addr = addr; h_wdata = data;
      @(negedge clk);
      h_req = 0; h_we = 0;
   endtask

   task automatic kacc(input int b, input logic we, input logic [15:0] addr,
                       input logic [31:0] data);
      @(negedge clk);
      k_en[b] = 1; k_we[b] = we; k_addr[b] = addr; k_wdata[b] = data;
      @(negedge clk);
      k_en[b] = 0; k_we[b] = 0;
   endtask

   task automatic go_round();
      @(negedge clk); h_go = 1;
      @(negedge clk); h_go = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      @(negedge clk); rst_n = 1;
   endtask

   typedef struct packed {
      logic        we;
      logic        rg;
      logic [1:0]  idx;
      logic [15:0] addr;
      logic [31:0] data;
   } vec_t;

   // idle host traffic; reads expect the data of the earlier write (R2, R3, R11)
   localparam vec_t VEC [10] = '{
      '{1'b1, 1'b1, 2'd0, 16'd0,  32'hA5A5_0001},
      '{1'b1, 1'b1, 2'd1, 16'd0,  32'h0000_00B2},
      '{1'b0, 1'b1, 2'd0, 16'd0,  32'hA5A5_0001},
      '{1'b1, 1'b0, 2'd2, 16'd3,  32'hC0DE_0003},
      '{1'b0, 1'b0, 2'd2, 16'd3,  32'hC0DE_0003},
      '{1'b1, 1'b0, 2'd0, 16'd1,  32'h0D0D_0001},
      '{1'b1, 1'b0, 2'd1, 16'd2,  32'h0E0E_0002},
      '{1'b0, 1'b1, 2'd1, 16'd0,  32'h0000_00B2},
      '{1'b1, 1'b0, 2'd2, 16'd15, 32'hFFFF_000F},
      '{1'b0, 1'b0, 2'd2, 16'd15, 32'hFFFF_000F}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      check("R12 err", 32'(h_err), 0);
      check("R12 busy", 32'(h_busy), 0);
      check("R12 start", 32'(k_start), 0);
      check("R12 rvalid", 32'(h_rvalid), 0);
      check("R12 count", k_count, 0);
      check("R12 reg0", k_reg_val[0], 0);

      foreach (VEC[i]) begin
         host(VEC[i].we, VEC[i].rg, VEC[i].idx, VEC[i].addr, VEC[i].data);
         if (!VEC[i].we) begin
            check($sformatf("R3 rvalid entry %0d", i), 32'(h_rvalid), 1);
            check($sformatf("R2/R11 rdata entry %0d", i), h_rdata, VEC[i].data);
         end
      end
      check("R10 count after 4 bank writes", k_count, 4);
      check("R2 no err on legal ops", 32'(h_err), 0);
      check("R11 reg0 to kernel", k_reg_val[0], 32'hA5A5_0001);

      // R11 kernel strobe beats host write in the same cycle
      @(negedge clk);
      k_reg_vld[1] = 1; k_reg_wr[1] = 32'h0000_0077;
      h_req = 1; h_we = 1; h_reg = 1; h_idx = 1; h_wdata = 32'h0000_0099;
      @(negedge clk);
      k_reg_vld[1] = 0; h_req = 0; h_we = 0;
      check("R11 kernel wins", k_reg_val[1], 32'h0000_0077);
      check("R10 reg writes not counted", k_count, 4);

      // R8 round start
      @(negedge clk); h_go = 1;
      @(negedge clk); h_go = 0;
      check("R8 start pulse", 32'(k_start), 1);
      check("R8 busy with start", 32'(h_busy), 1);
      check("R10 count zero at start", k_count, 0);
      @(negedge clk);
      check("R8 start one cycle", 32'(k_start), 0);
      go_round();
      check("R8 go while busy ignored", 32'(k_start), 0);

      // R6 kernel side
      kacc(0, 0, 16'd1, 0);
      check("R6 kernel reads const", k_rdata[0], 32'h0D0D_0001);
      kacc(1, 0, 16'd2, 0);
      check("R6 kernel reads input", k_rdata[1], 32'h0E0E_0002);
      kacc(2, 0, 16'd15, 0);
      check("R6 kernel reads inout", k_rdata[2], 32'hFFFF_000F);
      kacc(1, 1, 16'd2, 32'hBAD0_0001);
      kacc(1, 0, 16'd2, 0);
      check("R6 kernel write to input dropped", k_rdata[1], 32'h0E0E_0002);
      kacc(3, 1, 16'd5, 32'h5555_0005);
      kacc(2, 1, 16'd3, 32'h3333_0003);

      // R5 host blocked during round
      host(1, 0, 2'd2, 16'd3, 32'hBAD0_0002);
      kacc(2, 0, 16'd3, 0);
      check("R5 blocked host write", k_rdata[2], 32'h3333_0003);
      host(0, 0, 2'd2, 16'd3, 0);
      check("R5 blocked read rvalid", 32'(h_rvalid), 1);
      check("R5 blocked read zero", h_rdata, 0);
      check("R10 blocked writes not counted", k_count, 0);
      check("R4 err set by blocked access", 32'(h_err), 1);

      // R9 release
      @(negedge clk); k_ready = 1;
      @(negedge clk);
      check("R9 busy falls", 32'(h_busy), 0);

      host(0, 0, 2'd3, 16'd5, 0);
      check("R3 host reads output", h_rdata, 32'h5555_0005);
      host(0, 0, 2'd2, 16'd3, 0);
      check("R3 host reads inout", h_rdata, 32'h3333_0003);

      // R7 constant window
      host(1, 0, 2'd0, 16'd1, 32'h0BAD_0BAD);
      check("R7 closed window not counted", k_count, 0);
      @(negedge clk); h_reload = 1;
      @(negedge clk); h_reload = 0;
      host(1, 0, 2'd0, 16'd2, 32'h0CC2_0002);
      check("R7 reopened window counted", k_count, 1);
      go_round();
      @(negedge clk); k_ready = 0;
      kacc(0, 0, 16'd1, 0);
      check("R7 closed-window write dropped", k_rdata[0], 32'h0D0D_0001);
      kacc(0, 0, 16'd2, 0);
      check("R7 reopened write stored", k_rdata[0], 32'h0CC2_0002);
      @(negedge clk); k_ready = 1;
      @(negedge clk);
      check("R9 busy falls round 2", 32'(h_busy), 0);
      check("R4 err sticky", 32'(h_err), 1);

      // reset, then role errors
      do_reset();
      @(negedge clk);
      check("R12 err cleared", 32'(h_err), 0);
      check("R12 count cleared", k_count, 0);
      host(0, 0, 2'd1, 16'd2, 0);
      check("R1/R4 input read returns zero", h_rdata, 0);
      check("R1/R4 input read errs", 32'(h_err), 1);
      do_reset();
      host(1, 0, 2'd3, 16'd0, 32'h1);
      check("R1/R4 output write errs", 32'(h_err), 1);
      check("R1/R4 output write not counted", k_count, 0);
      do_reset();
      host(1, 0, 2'd2, 16'd16, 32'h1);
      check("R4 address out of range", 32'(h_err), 1);
      do_reset();
      host(1, 1, 2'd2, 16'd0, 32'h1);
      check("R4 register index out of range", 32'(h_err), 1);
      host(1, 0, 2'd0, 16'd0, 32'h0000_00C0);
      check("R12 window open after reset", k_count, 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule